// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from a page table held in memory. A requester hands over a virtual address together with the current value of the table base register. The walker first reads an entry in the top-level table, which names a second-level table. It then reads an entry in that second table, which names the physical page. The page number is joined with the untouched 12-bit page offset to form the result.

Either entry may be marked not valid. In that case the walk stops at once and the response carries a fault flag instead of an address. Resolving the fault is left to whoever consumes the response. Every request starts a fresh walk from the base register, so a retry after the tables are rewritten sees the new contents.

Memory is reached through a simple read port. The walker raises a one-cycle read request with an address and then waits for a data strobe, which may come any number of cycles later.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: A request is taken only in a cycle where `req_ready` and `req_valid` are both 1. The virtual address and the base register value are captured in that cycle. Changes to `req_vaddr`, `req_base` or `req_valid` while a walk is in progress have no effect on it.
- R3: In the cycle after a request is taken, `mem_req` is 1 for exactly one cycle. In that cycle `mem_addr` = base + VA[31:22] * 4.
- R4: After each read the walker waits for `mem_rdata_valid` and uses `mem_rdata` from that cycle. Strobes that arrive while no read is outstanding are ignored: they change neither the read sequence nor the response.
- R5: A table entry is valid when its bit 0 is 1. Bits [31:12] hold a table base or page number, and bits [11:1] are ignored. When the first-level entry is not valid, the walker issues no second read and responds with `rsp_fault` = 1 and `rsp_paddr` = 0.
- R6: When the first-level entry is valid, `mem_req` is 1 for exactly one cycle in the cycle after its data strobe. In that cycle `mem_addr` = {entry[31:12], 12'h000} + VA[21:12] * 4.
- R7: When the second-level entry is not valid, the response has `rsp_fault` = 1 and `rsp_paddr` = 0.
- R8: When the second-level entry is valid, the response has `rsp_fault` = 0 and `rsp_paddr` = {entry[31:12], VA[11:0]}.
- R9: The response appears in the cycle after the deciding data strobe. `rsp_valid`, `rsp_paddr` and `rsp_fault` then hold steady until a cycle with `rsp_ready` = 1, and `req_ready` is 1 in the following cycle.
- R10: No state carries over between requests. Repeating the same address after the table in memory has changed re-reads both levels and reports the new outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Page table base register value, byte address of the first-level table |
| mem_req | output | 1 | One-cycle entry read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rdata_valid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | An entry on the walk was not valid |

## Verification
The assertions take it for granted that memory returns exactly one data strobe for each read. That strobe comes no earlier than the cycle after `mem_req`, and no second read is issued before it arrives. The bench's memory responder keeps to this. It records each read on the falling edge and answers after a random delay of one to five cycles. Spare strobes carrying junk data are placed only where no read is outstanding, which includes the read-issue cycles themselves. The consumer may hold `rsp_ready` low for any time, and the bench varies that hold between requests.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_RD1   = 3'd1,
    WK_WT1   = 3'd2,
    WK_RD2   = 3'd3,
    WK_WT2   = 3'd4,
    WK_DONE  = 3'd5,
    WK_FAULT = 3'd6
  } walk_state_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       entry,
  output logic                   entry_ok,
  output logic [PTE_W-OFF_W-1:0] entry_page
);
  localparam int PAGE_W = PTE_W - OFF_W;

  function automatic logic flag_of(input logic [PTE_W-1:0] e);
    return e[0];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [PTE_W-1:0] e);
    return e[PTE_W-1:OFF_W];
  endfunction

  assign entry_ok   = flag_of(entry);
  assign entry_page = page_of(entry);

  // reserved field carries no meaning
  logic unused_rsv;
  assign unused_rsv = ^entry[OFF_W-1:1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W       = 10,
  parameter int OFF_W       = 12,
  parameter int PA_W        = 32,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic                    second_level,
  input  logic [2*IDX_W+OFF_W-1:0] vaddr,
  input  logic [PA_W-1:0]         root_base,
  input  logic [PA_W-OFF_W-1:0]   leaf_table_page,
  output logic [PA_W-1:0]         entry_addr
);
  localparam int VA_W   = 2*IDX_W + OFF_W;
  localparam int HI_LSB = OFF_W + IDX_W;

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] tbl,
                                                input logic [IDX_W-1:0] idx);
    return tbl + (PA_W'(idx) << ENTRY_SHIFT);
  endfunction

  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic [PA_W-1:0]  leaf_base;

  assign idx_hi    = vaddr[VA_W-1:HI_LSB];
  assign idx_lo    = vaddr[HI_LSB-1:OFF_W];
  assign leaf_base = {leaf_table_page, {OFF_W{1'b0}}};

  assign entry_addr = second_level ? slot_addr(leaf_base, idx_lo)
                                   : slot_addr(root_base, idx_hi);

  logic unused_off;
  assign unused_off = ^vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-1:0]       req_base,
  output logic                  mem_req,
  output logic                  second_level,
  input  logic                  mem_rdata_valid,
  input  logic                  entry_ok,
  input  logic [PA_W-OFF_W-1:0] entry_page,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  rsp_fault,
  output logic [VA_W-1:0]       va_q,
  output logic [PA_W-1:0]       base_q,
  output logic [PA_W-OFF_W-1:0] page_q
);
  localparam int PAGE_W = PA_W - OFF_W;

  walk_state_e state;

  function automatic logic [PA_W-1:0] join_pa(input logic [PAGE_W-1:0] pg,
                                              input logic [VA_W-1:0] va);
    return {pg, va[OFF_W-1:0]};
  endfunction

  // named events for assertions
  logic accept_evt, l1_hit_evt, l1_miss_evt, l2_done_evt, rsp_take_evt;
  assign accept_evt   = (state == WK_IDLE) && req_valid;
  assign l1_hit_evt   = (state == WK_WT1) && mem_rdata_valid && entry_ok;
  assign l1_miss_evt  = (state == WK_WT1) && mem_rdata_valid && !entry_ok;
  assign l2_done_evt  = (state == WK_WT2) && mem_rdata_valid;
  assign rsp_take_evt = rsp_valid && rsp_ready;

  assign req_ready    = (state == WK_IDLE);
  assign mem_req      = (state == WK_RD1) || (state == WK_RD2);
  assign second_level = (state == WK_RD2);
  assign rsp_valid    = (state == WK_DONE) || (state == WK_FAULT);
  assign rsp_fault    = (state == WK_FAULT);
  assign rsp_paddr    = (state == WK_DONE) ? join_pa(page_q, va_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WK_IDLE;
      va_q   <= '0;
      base_q <= '0;
      page_q <= '0;
    end else begin
      unique case (state)
        WK_IDLE: if (accept_evt) begin
          va_q   <= req_vaddr;
          base_q <= req_base;
          state  <= WK_RD1;
        end
        WK_RD1: state <= WK_WT1;
        WK_WT1: begin
          if (l1_hit_evt) begin
            page_q <= entry_page;
            state  <= WK_RD2;
          end else if (l1_miss_evt) begin
            state  <= WK_FAULT;
          end
        end
        WK_RD2: state <= WK_WT2;
        WK_WT2: if (l2_done_evt) begin
          page_q <= entry_page;
          state  <= entry_ok ? WK_DONE : WK_FAULT;
        end
        WK_DONE, WK_FAULT: if (rsp_ready) state <= WK_IDLE;
        default: state <= WK_IDLE;
      endcase
    end
  end

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_req && !second_level);

  // R6
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_hit_evt |=> mem_req && second_level);

  // R5
  early_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss_evt |=> rsp_valid && rsp_fault && !mem_req);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9
  back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take_evt |=> req_ready && !rsp_valid);

  // R3
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int IDX_W       = 10,
  parameter int OFF_W       = 12,
  parameter int PTE_W       = 32,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic [PTE_W-1:0]         req_base,
  output logic                     mem_req,
  output logic [PTE_W-1:0]         mem_addr,
  input  logic                     mem_rdata_valid,
  input  logic [PTE_W-1:0]         mem_rdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [PTE_W-1:0]         rsp_paddr,
  output logic                     rsp_fault
);
  localparam int VA_W   = 2*IDX_W + OFF_W;
  localparam int PA_W   = PTE_W;
  localparam int PAGE_W = PA_W - OFF_W;

  logic              second_level, entry_ok;
  logic [PAGE_W-1:0] entry_page, page_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;

  ptw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .entry      (mem_rdata),
    .entry_ok   (entry_ok),
    .entry_page (entry_page)
  );

  ptw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W),
                 .ENTRY_SHIFT(ENTRY_SHIFT)) u_agen (
    .second_level    (second_level),
    .vaddr           (va_q),
    .root_base       (base_q),
    .leaf_table_page (page_q),
    .entry_addr      (mem_addr)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .req_base        (req_base),
    .mem_req         (mem_req),
    .second_level    (second_level),
    .mem_rdata_valid (mem_rdata_valid),
    .entry_ok        (entry_ok),
    .entry_page      (entry_page),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_paddr       (rsp_paddr),
    .rsp_fault       (rsp_fault),
    .va_q            (va_q),
    .base_q          (base_q),
    .page_q          (page_q)
  );

endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0, mem_rdata_valid = 1'b0;
  logic [31:0] req_vaddr = '0, req_base = '0, mem_rdata = '0;
  logic        req_ready, mem_req, rsp_valid, rsp_fault;
  logic [31:0] mem_addr, rsp_paddr;

  int compared = 0, mismatched = 0, cycles = 0;
  bit stray_en = 1'b0;

  logic [31:0] pmem [logic [31:0]];

  always #2 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_base(req_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault));

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  // behavioural reference: walk step counter plus captured values
  int          ph = 0;
  logic [31:0] m_va = '0, m_base = '0, m_tbl = '0, m_pa = '0;
  bit          m_fault = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (req_valid) begin m_va = req_vaddr; m_base = req_base; ph = 1; end
        1: ph = 2;
        2: if (mem_rdata_valid) begin
             if (!mem_rdata[0]) begin m_fault = 1'b1; m_pa = 0; ph = 5; end
             else begin m_tbl = mem_rdata & 32'hFFFF_F000; ph = 3; end
           end
        3: ph = 4;
        4: if (mem_rdata_valid) begin
             m_fault = !mem_rdata[0];
             m_pa = m_fault ? 32'h0 : {mem_rdata[31:12], m_va[11:0]};
             ph = 5;
           end
        5: if (rsp_ready) ph = 0;
        default: ph = 0;
      endcase
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R1/R2 req_ready", 32'(req_ready), 32'(ph == 0));
      cmp("R3/R6 mem_req", 32'(mem_req), 32'(ph == 1 || ph == 3));
      cmp("R9 rsp_valid", 32'(rsp_valid), 32'(ph == 5));
      if (ph == 1) cmp("R3 first entry addr", mem_addr, m_base + {20'h0, m_va[31:22], 2'b00});
      if (ph == 3) cmp("R6 second entry addr", mem_addr, m_tbl + {20'h0, m_va[21:12], 2'b00});
      if (ph == 5) begin
        cmp("R5/R7 rsp_fault", 32'(rsp_fault), 32'(m_fault));
        cmp("R8 rsp_paddr", rsp_paddr, m_pa);
      end
    end else if (cycles > 1) begin
      cmp("R1 reset req_ready", 32'(req_ready), 32'd1);
      cmp("R1 reset mem_req", 32'(mem_req), 32'd0);
      cmp("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    end
  end

  // memory responder: R4 delay and spare strobes
  bit          pend = 1'b0;
  int          cnt = 0;
  logic [31:0] paddr_q = '0;
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      pend = 1'b1; paddr_q = mem_addr; cnt = int'($urandom_range(4, 0));
    end
  end
  initial begin
    forever begin
      @(posedge clk); #1;
      mem_rdata_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rdata_valid = 1'b1; mem_rdata = rd(paddr_q); pend = 1'b0;
        end else cnt--;
      end else if (stray_en && ($urandom_range(2, 0) == 0)) begin
        mem_rdata_valid = 1'b1; mem_rdata = $urandom; // R4 ignored strobe
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic xlate(input logic [31:0] va, input logic [31:0] base,
                       input int hold, input bit noise);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_base = base;
    @(posedge clk); #1;
    if (noise) begin
      // R2 busy-time changes must not matter
      req_vaddr = ~va; req_base = 32'h0F0F_0000; req_valid = 1'b1;
    end else req_valid = 1'b0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < hold; i++) @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    pmem[32'h0010_0004] = 32'h0020_0001;            // L1[1] valid
    pmem[32'h0010_0008] = 32'h0030_0FFE;            // L1[2] invalid, reserved set
    pmem[32'h0010_0FFC] = 32'h0040_07FF;            // L1[1023] valid, reserved set
    pmem[32'h0010_0000] = 32'h0050_0001;            // L1[0]
    pmem[32'h0020_0014] = 32'h0ABC_DFFF;            // L2 idx5
    pmem[32'h0020_0018] = 32'h1234_5000;            // L2 idx6 invalid
    pmem[32'h0040_0FFC] = 32'h0DEA_D001;            // L2 idx1023
    pmem[32'h0050_0000] = 32'hFFFF_F001;            // L2 idx0
    pmem[32'h0080_0004] = 32'h0060_0001;            // second root L1[1]
    pmem[32'h0060_0014] = 32'h7777_7001;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    xlate(32'h0040_5ABC, 32'h0010_0000, 0, 0);      // R8 hit
    xlate(32'h0080_5123, 32'h0010_0000, 2, 0);      // R5 first-level fault
    xlate(32'h0040_6777, 32'h0010_0000, 0, 0);      // R7 second-level fault
    xlate(32'hFFFF_FFFF, 32'h0010_0000, 3, 1);      // top index boundary, R2 noise
    xlate(32'h0000_0000, 32'h0010_0000, 0, 0);      // zero index boundary
    stray_en = 1'b1;                                // R4
    xlate(32'h0040_5001, 32'h0010_0000, 4, 1);
    xlate(32'h0080_5FFF, 32'h0010_0000, 1, 0);
    // R10: table rewritten, same address walks again
    pmem[32'h0020_0018] = 32'h1234_5001;
    xlate(32'h0040_6777, 32'h0010_0000, 0, 0);
    xlate(32'h0040_5ABC, 32'h0080_0000, 2, 1);      // other root table
    pmem[32'h0010_0004] = 32'h0020_0000;            // R10 first level now invalid
    xlate(32'h0040_5ABC, 32'h0010_0000, 0, 0);
    stray_en = 1'b0;
    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule